// File: doc/BRIEF.md
# Delayed Zero-Crossing Digital PLL Controller

This block steers the instants at which an external converter samples a sinusoidal input, closing a first-order digital phase-locked loop around those samples. A down-counter running on the system clock serves as the controlled oscillator. At the end of every period it raises a one-cycle sample request and loads its next period. Each signed sample returned by the converter enters a two-register holding pipeline. A gain-only loop filter then turns it into a period correction, and that correction shortens the nominal period.

Because a sample is still outstanding when the oscillator starts its next period, the period that begins at any request is built from the newest sample already returned. This is the sample requested one strobe earlier. The correction therefore acts two sample intervals behind the phase it measures, which relaxes the timing of the filter arithmetic. A second term adds a weighted difference of the two held samples to the correction. With a negative weight this term damps the loop and widens the usable gain range. A weight of zero leaves the plain delayed loop. The weight is clamped to a safe window, and the resulting period is saturated so that it can never collapse.

A lock flag reports a run of consecutive small samples. The flag drops on the first sample that is not small.

Top module: `zc_dpll_ctrl`

## Requirements
- R1: While `rst_n` is low, both held samples and the correction clear to zero, `locked` is 0 and `sample_req` is 0. `period_out` shows the nominal period, and the first `sample_req` rises exactly that many clock cycles after the last reset edge.
- R2: `sample_req` is a single-cycle pulse. The number of cycles from one pulse to the next equals the `period_out` value loaded together with the first of the two pulses, and `period_out` changes only together with a pulse.
- R3: The period loaded at each request is `nominal_period - c`, where `c` is computed from the samples already held when the request fires. The newest held sample is the one returned after the previous request.
- R4: The gain term is `loop_gain * x_new`, where `loop_gain` is signed two's complement with 12 fractional bits (4096 = 1.0) and `x_new` is a 12-bit signed sample.
- R5: The stabilizing term is `w * (x_new - x_old)`, where `x_old` is the sample held before `x_new`. The value `c` is the floor of `(gain term + stabilizing term) / 4096`.
- R6: With `stab_weight` = 0, `c` is exactly `floor(loop_gain * x_new / 4096)`.
- R7: The effective weight `w` is `stab_weight` clamped to the range -6144 (-1.5) to 0. A positive setting acts as 0, and a setting below -6144 acts as -6144.
- R8: The loaded period is saturated to the range 16 to 2^20-1 clock cycles. A nominal period below 16 also acts as 16.
- R9: The magnitude of a sample is its absolute value, so -2048 has magnitude 2048. `locked` rises after 64 consecutive samples whose magnitude is below `lock_thresh`. It clears on the first sample whose magnitude is equal to or above it.
- R10: The holding pipeline and the lock counter advance only on `sample_valid`. When no sample arrives within a period, the next period reuses the same held samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the oscillator counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| nominal_period | input | 20 | Free-running period in clock cycles |
| loop_gain | input | 16 | Signed filter gain with 12 fractional bits |
| stab_weight | input | 16 | Signed stabilizing weight with 12 fractional bits |
| lock_thresh | input | 12 | Unsigned magnitude bound for the lock run |
| sample_req | output | 1 | One-cycle strobe asking the converter for a sample |
| sample_valid | input | 1 | Marks a returned sample on `sample_data` |
| sample_data | input | 12 | Signed two's complement sample |
| period_out | output | 20 | Period currently being counted |
| locked | output | 1 | Lock indicator |

## Verification
A long run of small mixed-sign samples with zero weight checks the bare gain path, and it builds the lock run to its threshold. A ramp of larger samples with a negative weight separates the difference term from the gain term, and its first sample sits exactly at the threshold to test the lock boundary. The next patterns check the remaining behaviour. Rising and falling sample pairs are sent with out-of-window weights to show that the clamp is applied. Full-scale samples with large gains drive the period to its floor. Dropped samples show that the held values and the lock count stay put when no sample arrives.

// File: rtl/zcd_pkg.sv
// zcd_pkg: shared defaults for the delayed zero-crossing loop.
// Assumes all arithmetic is two's complement with a common fraction width.
package zcd_pkg;
    localparam int SAMPLE_W_DEF   = 12;
    localparam int COEF_W_DEF     = 16;
    localparam int FRAC_W_DEF     = 12;
    localparam int PERIOD_W_DEF   = 20;
    localparam int MIN_PERIOD_DEF = 16;
    localparam int LOCK_RUN_DEF   = 64;
    localparam int W_FLOOR_DEF    = -6144;

    // Sign of a two's complement held sample, used to pick the magnitude path.
    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } sign_e;
endpackage

// File: rtl/zcd_sample_pipe.sv
// zcd_sample_pipe: two-register sample holding pipeline plus lock tracking.
// Register I captures a returned sample. One cycle later the sample moves
// to register II (the newest held sample), the old newest becomes the older
// held sample, and register I clears. Assumes sample_valid is a one-cycle
// qualifier and that samples arrive no more often than every other cycle
// for the lock count to see each one (a back-to-back one still transfers).
module zcd_sample_pipe
    import zcd_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int LOCK_RUN = LOCK_RUN_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic        [SAMPLE_W-1:0] mag_limit,
    output logic signed [SAMPLE_W-1:0] held_new,
    output logic signed [SAMPLE_W-1:0] held_old,
    output logic                       lock_flag
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

    logic signed [SAMPLE_W-1:0] stage_i;
    logic                       stage_full;
    logic        [SAMPLE_W-1:0] stage_mag;
    logic        [RUN_W-1:0]    run_cnt;
    logic        [RUN_W-1:0]    run_next;
    sign_e                      stage_sgn;

    // Magnitude of the sample waiting in register I.
    always_comb begin
        stage_sgn = sign_e'(stage_i[SAMPLE_W-1]);
        if (stage_sgn == SGN_NEG) begin
            stage_mag = ~stage_i + 1'b1;
        end else begin
            stage_mag = stage_i;
        end
    end

    // Next value of the run of consecutive small samples, saturating.
    always_comb begin
        if (stage_mag >= mag_limit) begin
            run_next = '0;
        end else if (run_cnt == RUN_MAX) begin
            run_next = run_cnt;
        end else begin
            run_next = run_cnt + 1'b1;
        end
    end

    // Register I: capture on valid, clear after handing the sample on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_i    <= '0;
            stage_full <= 1'b0;
        end else if (smp_valid) begin
            stage_i    <= smp_data;
            stage_full <= 1'b1;
        end else if (stage_full) begin
            stage_i    <= '0;
            stage_full <= 1'b0;
        end
    end

    // Register II and the older copy: shift when register I holds a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_new <= '0;
            held_old <= '0;
        end else if (stage_full) begin
            held_new <= stage_i;
            held_old <= held_new;
        end
    end

    // Lock run counter and flag, updated with each transferred sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            lock_flag <= 1'b0;
        end else if (stage_full) begin
            run_cnt   <= run_next;
            lock_flag <= (run_next == RUN_MAX);
        end
    end
endmodule

// File: rtl/zcd_loop_filter.sv
// zcd_loop_filter: gain-only loop filter with a weighted-difference
// stabilizing term. Produces the registered period correction
// floor((gain*new + w*(new-old)) / 2^FRAC_W), with w clamped to
// [W_FLOOR, 0]. Assumes both coefficients share FRAC_W fractional bits.
module zcd_loop_filter
    import zcd_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int COEF_W   = COEF_W_DEF,
    parameter int FRAC_W   = FRAC_W_DEF,
    parameter int W_FLOOR  = W_FLOOR_DEF,
    parameter int ACC_W    = COEF_W + SAMPLE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [COEF_W-1:0]   gain,
    input  logic signed [COEF_W-1:0]   weight,
    input  logic signed [SAMPLE_W-1:0] held_new,
    input  logic signed [SAMPLE_W-1:0] held_old,
    output logic signed [ACC_W-1:0]    corr_q
);
    localparam logic signed [COEF_W-1:0] W_LOW = COEF_W'(W_FLOOR);

    logic signed [COEF_W-1:0] w_eff;
    logic signed [ACC_W-1:0]  diff;
    logic signed [ACC_W-1:0]  gain_term;
    logic signed [ACC_W-1:0]  stab_term;
    logic signed [ACC_W-1:0]  acc;

    // Clamp the stabilizing weight into its safe window.
    always_comb begin
        if (weight > 0) begin
            w_eff = '0;
        end else if (weight < W_LOW) begin
            w_eff = W_LOW;
        end else begin
            w_eff = weight;
        end
    end

    // Gain and difference products, summed at full precision.
    always_comb begin
        diff      = ACC_W'(held_new) - ACC_W'(held_old);
        gain_term = ACC_W'(gain) * ACC_W'(held_new);
        stab_term = ACC_W'(w_eff) * diff;
        acc       = gain_term + stab_term;
    end

    // Register the floored correction for the oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= '0;
        end else begin
            corr_q <= acc >>> FRAC_W;
        end
    end
endmodule

// File: rtl/zcd_dco.sv
// zcd_dco: clock-counting oscillator. Loads nominal minus correction,
// saturated to [MIN_PERIOD, 2^PERIOD_W-1], and raises a one-cycle request
// each time a period ends. Assumes the correction is settled a few cycles
// before the period ends.
module zcd_dco
    import zcd_pkg::*;
#(
    parameter int PERIOD_W   = PERIOD_W_DEF,
    parameter int ACC_W      = 30,
    parameter int MIN_PERIOD = MIN_PERIOD_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PERIOD_W-1:0]     nominal,
    input  logic signed [ACC_W-1:0] corr,
    output logic [PERIOD_W-1:0]     period_q,
    output logic                    req_q
);
    localparam int WIDE_W = ACC_W + PERIOD_W + 1;
    localparam logic signed [WIDE_W-1:0] WMIN = WIDE_W'(MIN_PERIOD);
    localparam logic signed [WIDE_W-1:0] WMAX =
        {{(WIDE_W-PERIOD_W){1'b0}}, {PERIOD_W{1'b1}}};
    localparam logic [PERIOD_W-1:0] PMIN = PERIOD_W'(MIN_PERIOD);

    logic signed [WIDE_W-1:0] raw;
    logic [PERIOD_W-1:0]      next_period;
    logic [PERIOD_W-1:0]      nom_sat;
    logic [PERIOD_W-1:0]      cnt;

    // Corrected period, saturated into the legal range.
    always_comb begin
        raw = $signed({{(WIDE_W-PERIOD_W){1'b0}}, nominal}) - WIDE_W'(corr);
        if (raw < WMIN) begin
            next_period = PMIN;
        end else if (raw > WMAX) begin
            next_period = {PERIOD_W{1'b1}};
        end else begin
            next_period = raw[PERIOD_W-1:0];
        end
    end

    // Nominal period with the same floor, used straight out of reset.
    always_comb begin
        nom_sat = (nominal < PMIN) ? PMIN : nominal;
    end

    // Period counter, request strobe and observed period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= nom_sat;
            period_q <= nom_sat;
            req_q    <= 1'b0;
        end else if (cnt <= 1) begin
            cnt      <= next_period;
            period_q <= next_period;
            req_q    <= 1'b1;
        end else begin
            cnt   <= cnt - 1'b1;
            req_q <= 1'b0;
        end
    end
endmodule

// File: rtl/zc_dpll_ctrl.sv
// zc_dpll_ctrl: first-order delayed zero-crossing DPLL controller.
// Wires the sample holding pipeline, the loop filter and the oscillator.
// Assumes the converter answers each request within a few cycles.
module zc_dpll_ctrl
    import zcd_pkg::*;
#(
    parameter int SAMPLE_W   = SAMPLE_W_DEF,
    parameter int COEF_W     = COEF_W_DEF,
    parameter int FRAC_W     = FRAC_W_DEF,
    parameter int PERIOD_W   = PERIOD_W_DEF,
    parameter int MIN_PERIOD = MIN_PERIOD_DEF,
    parameter int LOCK_RUN   = LOCK_RUN_DEF,
    parameter int W_FLOOR    = W_FLOOR_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] nominal_period,
    input  logic [COEF_W-1:0]   loop_gain,
    input  logic [COEF_W-1:0]   stab_weight,
    input  logic [SAMPLE_W-1:0] lock_thresh,
    output logic                sample_req,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic [PERIOD_W-1:0] period_out,
    output logic                locked
);
    localparam int ACC_W = COEF_W + SAMPLE_W + 2;

    logic signed [SAMPLE_W-1:0] held_new;
    logic signed [SAMPLE_W-1:0] held_old;
    logic signed [ACC_W-1:0]    corr;

    zcd_sample_pipe #(
        .SAMPLE_W (SAMPLE_W),
        .LOCK_RUN (LOCK_RUN)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (sample_valid),
        .smp_data  ($signed(sample_data)),
        .mag_limit (lock_thresh),
        .held_new  (held_new),
        .held_old  (held_old),
        .lock_flag (locked)
    );

    zcd_loop_filter #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .FRAC_W   (FRAC_W),
        .W_FLOOR  (W_FLOOR),
        .ACC_W    (ACC_W)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .gain     ($signed(loop_gain)),
        .weight   ($signed(stab_weight)),
        .held_new (held_new),
        .held_old (held_old),
        .corr_q   (corr)
    );

    zcd_dco #(
        .PERIOD_W   (PERIOD_W),
        .ACC_W      (ACC_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_dco (
        .clk      (clk),
        .rst_n    (rst_n),
        .nominal  (nominal_period),
        .corr     (corr),
        .period_q (period_out),
        .req_q    (sample_req)
    );
endmodule

// File: rtl/zcd_checker.sv
// zcd_checker: temporal properties of zc_dpll_ctrl, bound to every instance.
// Assumes lock_thresh is held steady around each sample.
module zcd_checker #(
    parameter int SAMPLE_W   = 12,
    parameter int PERIOD_W   = 20,
    parameter int MIN_PERIOD = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_req,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] sample_data,
    input logic [SAMPLE_W-1:0] lock_thresh,
    input logic [PERIOD_W-1:0] period_out,
    input logic                locked
);
    logic [PERIOD_W:0]     gap;
    logic [PERIOD_W-1:0]   last_p;
    logic                  seen;
    logic [SAMPLE_W-1:0]   in_mag;

    // Magnitude of the incoming sample.
    always_comb begin
        in_mag = sample_data[SAMPLE_W-1] ? (~sample_data + 1'b1) : sample_data;
    end

    // Cycles since the last request and the period loaded with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap    <= '0;
            last_p <= '0;
            seen   <= 1'b0;
        end else if (sample_req) begin
            gap    <= 1;
            last_p <= period_out;
            seen   <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    AST_RESET_CLEARS_LOCK: assert property (@(posedge clk) !rst_n |=> !locked); // R1
    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sample_req |=> !sample_req); // R2
    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (sample_req && seen) |-> (gap == {1'b0, last_p})); // R2
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !sample_req |-> $stable(period_out)); // R2
    AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) period_out >= PERIOD_W'(MIN_PERIOD)); // R8
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (sample_valid && in_mag >= lock_thresh) |=> ##1 !locked); // R9
    AST_LOCK_MOVES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) (locked != $past(locked)) |-> $past(sample_valid, 2)); // R10
endmodule

bind zc_dpll_ctrl zcd_checker #(
    .SAMPLE_W   (SAMPLE_W),
    .PERIOD_W   (PERIOD_W),
    .MIN_PERIOD (MIN_PERIOD)
) u_zcd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_req   (sample_req),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .lock_thresh  (lock_thresh),
    .period_out   (period_out),
    .locked       (locked)
);

// File: tb/test_zc_dpll_ctrl.sv
// test_zc_dpll_ctrl: scoreboard bench. The driver answers each request,
// updates a reference model and queues the expected state for the next
// request. The monitor pops one item per request and compares.
module test_zc_dpll_ctrl;
    localparam int T0 = 200;

    typedef struct {
        int    period;
        bit    lck;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] nominal_period = 20'(T0);
    logic [15:0] loop_gain = 16'd2048;
    logic [15:0] stab_weight = 16'd0;
    logic [11:0] lock_thresh = 12'd100;
    logic        sample_req;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_data = '0;
    logic [19:0] period_out;
    logic        locked;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    exp_t expq[$];

    int m_new = 0;
    int m_old = 0;
    int m_run = 0;
    int m_g = 2048;
    int m_b = 0;

    always #5 clk = ~clk;

    zc_dpll_ctrl i_zc_dpll_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .nominal_period (nominal_period),
        .loop_gain      (loop_gain),
        .stab_weight    (stab_weight),
        .lock_thresh    (lock_thresh),
        .sample_req     (sample_req),
        .sample_valid   (sample_valid),
        .sample_data    (sample_data),
        .period_out     (period_out),
        .locked         (locked)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int clamp_w(input int b);
        if (b > 0) return 0;
        if (b < -6144) return -6144;
        return b;
    endfunction

    function automatic int model_period();
        longint s;
        longint c;
        longint p;
        s = longint'(m_g) * m_new + longint'(clamp_w(m_b)) * (m_new - m_old);
        c = s >>> 12;
        p = T0 - c;
        if (p < 16) p = 16;
        if (p > 1048575) p = 1048575;
        return int'(p);
    endfunction

    // Answer one request (or skip it), then apply the next settings.
    task automatic step(input bit send, input int data, input int g,
                        input int b, input string tag);
        int mag;
        do @(negedge clk); while (!sample_req);
        if (send) begin
            sample_valid = 1'b1;
            sample_data  = 12'(data);
            @(negedge clk);
            sample_valid = 1'b0;
        end
        loop_gain   = 16'(g);
        stab_weight = 16'(b);
        m_g = g;
        m_b = b;
        if (send) begin
            m_old = m_new;
            m_new = data;
            mag = (data < 0) ? -data : data;
            if (mag < int'(lock_thresh)) m_run = (m_run < 64) ? m_run + 1 : 64;
            else m_run = 0;
        end
        expq.push_back('{model_period(), (m_run == 64), tag});
    endtask

    // Monitor: each request checks spacing, loaded period and lock flag.
    initial begin
        int   gap;
        int   last_p;
        exp_t e;
        wait (mon_en);
        gap = 0;
        last_p = T0;
        forever begin
            @(negedge clk);
            if (!mon_en) continue;
            gap++;
            if (sample_req) begin
                check(gap == last_p, "R2 R1", "request spacing", gap, last_p);
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "queue empty", 0, 1);
                end else begin
                    e = expq.pop_front();
                    check(int'(period_out) == e.period, {"R3 ", e.tag}, "period_out",
                          period_out, e.period);
                    check(locked == e.lck, {"R9 ", e.tag}, "locked", locked, e.lck);
                end
                last_p = int'(period_out);
                gap = 0;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int seq_b[10] = '{100, 300, -200, 700, 0, -900, 400, 50, -50, 1000};
        repeat (4) @(negedge clk);
        // R1: reset state
        check(period_out == 20'(T0), "R1", "period_out in reset", period_out, T0);
        check(locked == 1'b0, "R1", "locked in reset", locked, 0);
        check(sample_req == 1'b0, "R1", "sample_req in reset", sample_req, 0);
        expq.push_back('{T0, 1'b0, "R1"});
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R4 R6 R9: small mixed samples, zero weight, builds the lock run
        for (int i = 0; i < 66; i++) begin
            step(1'b1, ((i * 37) % 181) - 90, 2048, 0, "R4 R6");
        end
        // R5 R9: ramp with negative weight; first sample equals threshold
        for (int i = 0; i < 10; i++) begin
            step(1'b1, seq_b[i], 2048, -1638, "R5");
        end
        // R10: dropped samples leave the correction unchanged
        step(1'b1, 600, 2048, -1638, "R10");
        step(1'b0, 0, 2048, -1638, "R10");
        step(1'b0, 0, 2048, -1638, "R10");
        step(1'b1, -300, 2048, -1638, "R10");
        // R7: weight clamped at both ends
        step(1'b1, 500, 2048, 3000, "R7");
        step(1'b1, -500, 2048, 3000, "R7");
        step(1'b1, -500, 2048, -20000, "R7");
        step(1'b1, 500, 2048, -20000, "R7");
        step(1'b1, -400, 2048, -20000, "R7");
        // R8: corrections beyond the nominal period hit the floor
        step(1'b1, 2000, 16384, 0, "R8");
        step(1'b1, -2048, -32768, 0, "R8");
        step(1'b1, 2047, 16384, 0, "R8");
        step(1'b1, 1000, -4096, 0, "R4");
        step(1'b1, 20, 2048, 0, "R4");
        step(1'b0, 0, 2048, 0, "R10");

        // R8 R1: nominal below the floor, fresh reset
        mon_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        nominal_period = 20'd5;
        repeat (3) @(negedge clk);
        check(period_out == 20'd16, "R8", "floored nominal", period_out, 16);
        check(locked == 1'b0, "R1", "locked after reset", locked, 0);
        finish_run();
    end
endmodule